// File: doc/BRIEF.md
# Multi-mode UART baud tick generator

This block makes the timing strobes for a four-mode serial port, all inside one system-clock domain. Nothing here is a generated clock. Every rate is a one-cycle enable pulse.

A shared prescaler first slows the system clock by 1, 2, 4, 8 or a power-saving 256. How the prescaled rate is used then depends on the port mode:

- Mode 0 (synchronous shift) divides it by 12 or by 4.
- Mode 2 (fixed asynchronous) divides it by 64 or by 32.
- Modes 1 and 3 (variable asynchronous) feed a programmable phase accumulator. The accumulator is stepped either on every prescaled cycle or on every fourth one. Each carry out of its top bit becomes a receiver sample tick, and every sixteenth sample tick becomes a bit tick.

The shifter and framing logic next to this block use `bit_tick` as their bit-rate strobe. The receiver uses `sample_tick` to oversample the line by 16. Whenever the control inputs change, all internal counters restart, so a new setting never produces a shortened first period.

Top module: `baud_tick_gen`

## Requirements
- R1: With `mode_sel`=0, `bit_tick` pulses once every P*12 cycles when `sync_fast`=0 and once every P*4 cycles when `sync_fast`=1, where P is the prescale ratio. `rate_dbl` has no effect, and `sample_tick` stays low.
- R2: With `mode_sel`=2, `sample_tick` pulses every P*4 cycles when `rate_dbl`=0 and every P*2 cycles when `rate_dbl`=1. `bit_tick` pulses together with every 16th sample tick, giving P*64 or P*32. `sync_fast` has no effect.
- R3: With `mode_sel`=1 or 3, a wrapping accumulator of ACC_W bits adds `phase_inc` once per step. A step occurs on every prescaled cycle when `rate_dbl`=1 and on every 4th prescaled cycle when `rate_dbl`=0. `sample_tick` pulses one cycle after each step whose sum carries out of the top bit.
- R4: In modes 1, 2 and 3, `bit_tick` pulses in the same cycle as every 16th `sample_tick` counted from the last restart, and never without one.
- R5: `pre_sel` encodes the prescale ratio P: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 8, and any value from 4 to 7 gives 256.
- R6: A restart occurs on the first clock edge at which any of `mode_sel`, `sync_fast`, `rate_dbl` or `pre_sel` differs from its value at the previous edge. On that edge both ticks are low in the following cycle, and every counter and the accumulator return to zero. The first tick after the restart then comes a full period later. If the restart edge is counted as edge 1, a tick with period T is seen after edge T+1.
- R7: While `rst_n` is low both ticks are low. The first edge after `rst_n` rises is a restart edge, with the same timing as in R6.
- R8: In modes 1 and 3 with `phase_inc`=0, neither tick ever pulses.
- R9: `bit_tick` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Serial port mode 0..3 |
| sync_fast | input | 1 | Mode 0 rate select: 0 gives /12, 1 gives /4 |
| rate_dbl | input | 1 | Rate doubler for modes 1, 2 and 3 |
| pre_sel | input | 3 | System-clock prescale select |
| phase_inc | input | ACC_W | Phase accumulator increment |
| bit_tick | output | 1 | One-cycle bit-rate (or shift-rate) strobe |
| sample_tick | output | 1 | One-cycle x16 oversampling strobe, modes 1, 2 and 3 |

## Verification
The bench builds the block with its default parameters: a 16-bit accumulator, a power-saving ratio of 256, x16 oversampling and the standard fixed ratios. With these values, single-bit increments such as 0x8000, 0x1000 or 0x2000 give exact, hand-computable periods. The largest setting, mode 2 at ratio 256, still completes two full bit periods within the run. An increment of 0xFFFF brings within reach a carry on every step after the first, so sample ticks arrive back to back. Restarts are exercised in the middle of a period and at the release of reset.

// File: rtl/baud_pkg.sv
`timescale 1ns/1ps
// Package: shared mode encoding and prescale decode for the baud tick generator.
// Assumes pre_sel values 4..7 all select the power-saving ratio.
package baud_pkg;

    typedef enum logic [1:0] {
        PMODE_SHIFT = 2'd0,
        PMODE_VAR_A = 2'd1,
        PMODE_FIXED = 2'd2,
        PMODE_VAR_B = 2'd3
    } port_mode_e;

    // Prescale ratio chosen by the select code.
    function automatic int unsigned pre_ratio(input logic [2:0] sel, input int unsigned pm_div);
        case (sel)
            3'd0:    return 1;
            3'd1:    return 2;
            3'd2:    return 4;
            3'd3:    return 8;
            default: return pm_div;
        endcase
    endfunction

endpackage

// File: rtl/baud_modcnt.sv
`timescale 1ns/1ps
// Module: modulo counter used as a clock-enable divider.
// Counts enabled cycles from 0 to 'last' and flags the enabled cycle at 'last'.
// Assumes 'last' only changes together with a synchronous clear.
module baud_modcnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic [W-1:0] last,
    output logic         hit
);

    logic [W-1:0] cnt;

    assign hit = en && (cnt == last);

    // Advance on enable, wrap at the terminal value, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (en)  cnt <= hit ? '0 : cnt + 1'b1;
    end

endmodule

// File: rtl/baud_prescale.sv
`timescale 1ns/1ps
// Module: system-clock prescaler producing one enable per P cycles.
// With P = 1 the enable is high every cycle. Assumes PM_DIV >= 8.
module baud_prescale #(
    parameter int PM_DIV = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic [2:0] sel,
    output logic       pre_tick
);
    import baud_pkg::*;

    localparam int PW = $clog2(PM_DIV);

    logic [PW-1:0] last;

    // Decode the ratio select into a terminal count.
    always_comb begin
        last = PW'(pre_ratio(sel, PM_DIV) - 1);
    end

    baud_modcnt #(.W(PW)) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (1'b1),
        .last (last),
        .hit  (pre_tick)
    );

endmodule

// File: rtl/baud_phase_acc.sv
`timescale 1ns/1ps
// Module: wrapping phase accumulator.
// Adds 'inc' on each step and flags a step whose sum carries out of the top bit.
module baud_phase_acc #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    input  logic [W-1:0] inc,
    output logic         carry
);

    logic [W-1:0] acc;
    logic [W:0]   sum;

    assign sum   = {1'b0, acc} + {1'b0, inc};
    assign carry = step && sum[W];

    // Hold the phase between steps; restart at zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)    acc <= '0;
        else if (clr)  acc <= '0;
        else if (step) acc <= sum[W-1:0];
    end

endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
// Module: multi-mode baud tick generator (top).
// Builds shift, bit and x16 sample strobes from one system clock.
// Any change of the control inputs restarts all counters. Outputs are registered.
module baud_tick_gen #(
    parameter int ACC_W      = 16,
    parameter int PM_DIV     = 256,
    parameter int OVS        = 16,
    parameter int M0_SLOW    = 12,
    parameter int M0_FAST    = 4,
    parameter int M2_SLOW    = 64,
    parameter int M2_FAST    = 32,
    parameter int ACC_PREDIV = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             sync_fast,
    input  logic             rate_dbl,
    input  logic [2:0]       pre_sel,
    input  logic [ACC_W-1:0] phase_inc,
    output logic             bit_tick,
    output logic             sample_tick
);
    import baud_pkg::*;

    localparam int DW   = $clog2(M0_SLOW + M2_SLOW + ACC_PREDIV);
    localparam int OW   = $clog2(OVS);
    localparam int CFGW = 7;

    port_mode_e      mode;
    logic [CFGW-1:0] cfg, cfg_q;
    logic            started, clr;
    logic            pre_tick, div_hit, acc_carry, acc_step;
    logic            x16_hit, samp_raw, bit_raw;
    logic [DW-1:0]   div_last;
    logic            is_acc;

    assign mode   = port_mode_e'(mode_sel);
    assign cfg    = {mode_sel, sync_fast, rate_dbl, pre_sel};
    assign is_acc = (mode == PMODE_VAR_A) || (mode == PMODE_VAR_B);
    assign clr    = !started || (cfg != cfg_q);

    // Remember the last control setting so that a change can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q   <= '0;
            started <= 1'b0;
        end else begin
            cfg_q   <= cfg;
            started <= 1'b1;
        end
    end

    baud_prescale #(.PM_DIV(PM_DIV)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .sel     (pre_sel),
        .pre_tick(pre_tick)
    );

    // Pick the ratio of the second divider from the mode and rate bits.
    always_comb begin
        case (mode)
            PMODE_SHIFT: div_last = sync_fast ? DW'(M0_FAST - 1) : DW'(M0_SLOW - 1);
            PMODE_FIXED: div_last = rate_dbl  ? DW'(M2_FAST / OVS - 1) : DW'(M2_SLOW / OVS - 1);
            default:     div_last = DW'(ACC_PREDIV - 1);
        endcase
    end

    baud_modcnt #(.W(DW)) u_div (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (pre_tick),
        .last (div_last),
        .hit  (div_hit)
    );

    assign acc_step = is_acc && (rate_dbl ? pre_tick : div_hit);

    baud_phase_acc #(.W(ACC_W)) u_acc (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .step (acc_step),
        .inc  (phase_inc),
        .carry(acc_carry)
    );

    // Route the sample-rate source for the current mode.
    always_comb begin
        case (mode)
            PMODE_FIXED: samp_raw = div_hit;
            PMODE_SHIFT: samp_raw = 1'b0;
            default:     samp_raw = acc_carry;
        endcase
    end

    baud_modcnt #(.W(OW)) u_x16 (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (clr),
        .en   (samp_raw),
        .last (OW'(OVS - 1)),
        .hit  (x16_hit)
    );

    assign bit_raw = (mode == PMODE_SHIFT) ? div_hit : x16_hit;

    // Register the strobes and suppress them on a restart edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_tick    <= 1'b0;
            sample_tick <= 1'b0;
        end else begin
            bit_tick    <= bit_raw  && !clr;
            sample_tick <= samp_raw && !clr;
        end
    end

endmodule

// File: rtl/baud_tick_gen_chk.sv
`timescale 1ns/1ps
// Module: assertion checker bound to baud_tick_gen.
// Watches the ports only.
module baud_tick_gen_chk #(
    parameter int ACC_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode_sel,
    input logic             sync_fast,
    input logic             rate_dbl,
    input logic [2:0]       pre_sel,
    input logic [ACC_W-1:0] phase_inc,
    input logic             bit_tick,
    input logic             sample_tick
);

    logic [6:0] cfg;
    assign cfg = {mode_sel, sync_fast, rate_dbl, pre_sel};

    // R1
    shift_mode_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_tick |-> ($past(mode_sel) != 2'd0));

    // R4
    bit_with_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && $past(mode_sel) != 2'd0) |-> sample_tick);

    // R6
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg != $past(cfg)) |=> (!bit_tick && !sample_tick));

    // R8
    zero_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel[0]) && $past(phase_inc) == '0) |-> !sample_tick);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |=> !bit_tick);

    // R7
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!bit_tick && !sample_tick));

endmodule

bind baud_tick_gen baud_tick_gen_chk #(.ACC_W(ACC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .sync_fast  (sync_fast),
    .rate_dbl   (rate_dbl),
    .pre_sel    (pre_sel),
    .phase_inc  (phase_inc),
    .bit_tick   (bit_tick),
    .sample_tick(sample_tick)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
// Bench: table-driven period checks, then directed reset and corner tests.
module baud_tick_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'd0;
    logic        sync_fast = 1'b0;
    logic        rate_dbl = 1'b0;
    logic [2:0]  pre_sel = 3'd0;
    logic [15:0] phase_inc = 16'd0;
    logic        bit_tick, sample_tick;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    baud_tick_gen u_baud_tick_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_sel   (mode_sel),
        .sync_fast  (sync_fast),
        .rate_dbl   (rate_dbl),
        .pre_sel    (pre_sel),
        .phase_inc  (phase_inc),
        .bit_tick   (bit_tick),
        .sample_tick(sample_tick)
    );

    typedef struct packed {
        logic [1:0]  mode;
        logic        fast;
        logic        dbl;
        logic [2:0]  pre;
        logic [15:0] inc;
        int unsigned bitp;
        int unsigned sampp;
    } vec_t;

    // Expected periods worked out by hand from R1..R5.
    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 1'b0, 3'd0, 16'h0000,    12,    0},
        '{2'd0, 1'b1, 1'b0, 3'd0, 16'h0000,     4,    0},
        '{2'd0, 1'b0, 1'b1, 3'd1, 16'h0000,    24,    0},
        '{2'd0, 1'b1, 1'b0, 3'd3, 16'h0000,    32,    0},
        '{2'd0, 1'b0, 1'b0, 3'd4, 16'h0000,  3072,    0},
        '{2'd2, 1'b0, 1'b0, 3'd0, 16'h0000,    64,    4},
        '{2'd2, 1'b0, 1'b1, 3'd0, 16'h0000,    32,    2},
        '{2'd2, 1'b0, 1'b1, 3'd2, 16'h0000,   128,    8},
        '{2'd2, 1'b1, 1'b0, 3'd1, 16'h0000,   128,    8},
        '{2'd1, 1'b0, 1'b1, 3'd0, 16'h8000,    32,    2},
        '{2'd1, 1'b0, 1'b0, 3'd0, 16'h8000,   128,    8},
        '{2'd3, 1'b0, 1'b1, 3'd1, 16'h4000,   128,    8},
        '{2'd3, 1'b0, 1'b0, 3'd3, 16'h1000,  8192,  512},
        '{2'd2, 1'b0, 1'b0, 3'd4, 16'h0000, 16384, 1024},
        '{2'd1, 1'b0, 1'b1, 3'd0, 16'h2000,   128,    8}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply a setting (and release reset), then watch 'limit' cycles.
    // n counts edges after the drive; edge 1 is the restart edge.
    task automatic run_cfg(input logic [1:0] m, input logic f, input logic d,
                           input logic [2:0] p, input logic [15:0] inc, input int limit,
                           output int b1, output int b2, output int s1, output int s2,
                           output int sc, output int bc, output int dbl, output int miss);
        bit prevb;
        @(negedge clk);
        rst_n = 1'b1; mode_sel = m; sync_fast = f; rate_dbl = d; pre_sel = p; phase_inc = inc;
        b1 = -1; b2 = -1; s1 = -1; s2 = -1; sc = 0; bc = 0; dbl = 0; miss = 0; prevb = 1'b0;
        for (int n = 1; n <= limit; n++) begin
            @(posedge clk);
            @(negedge clk);
            if (bit_tick) begin
                bc++;
                if (b1 < 0) b1 = n; else if (b2 < 0) b2 = n;
                if (prevb) dbl++;
                if (m != 2'd0 && !sample_tick) miss++;
            end
            if (sample_tick) begin
                sc++;
                if (s1 < 0) s1 = n; else if (s2 < 0) s2 = n;
            end
            prevb = bit_tick;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int b1, b2, s1, s2, sc, bc, dbl, miss;
        string rq;

        // R7: strobes low while reset is held
        mode_sel = 2'd0; sync_fast = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!bit_tick && !sample_tick, "R7 reset low", int'(bit_tick) + int'(sample_tick), 0);
        end
        // R7: first edge after release restarts, shift period 4
        run_cfg(2'd0, 1'b1, 1'b0, 3'd0, 16'h0, 12, b1, b2, s1, s2, sc, bc, dbl, miss);
        chk(b1 == 5, "R7 first tick after release", b1, 5);
        chk(b2 - b1 == 4, "R7 period after release", b2 - b1, 4);

        // Table walk: R1 R2 R3 R4 R5
        for (int v = 0; v < NV; v++) begin
            rq = (VECS[v].mode == 2'd0) ? "R1" : (VECS[v].mode == 2'd2) ? "R2" : "R3";
            run_cfg(VECS[v].mode, VECS[v].fast, VECS[v].dbl, VECS[v].pre, VECS[v].inc,
                    int'(2 * VECS[v].bitp + 2), b1, b2, s1, s2, sc, bc, dbl, miss);
            chk(b1 == int'(VECS[v].bitp) + 1, {rq, " R5 R6 first bit tick"}, b1, int'(VECS[v].bitp) + 1);
            chk(b2 - b1 == int'(VECS[v].bitp), {rq, " R4 R5 bit period"}, b2 - b1, int'(VECS[v].bitp));
            chk(dbl == 0, "R9 back-to-back bit tick", dbl, 0);
            if (VECS[v].sampp == 0) begin
                chk(sc == 0, "R1 no sample tick in shift mode", sc, 0);
            end else begin
                chk(s1 == int'(VECS[v].sampp) + 1, {rq, " first sample tick"}, s1, int'(VECS[v].sampp) + 1);
                chk(s2 - s1 == int'(VECS[v].sampp), {rq, " sample period"}, s2 - s1, int'(VECS[v].sampp));
                chk(miss == 0, "R4 bit tick without sample tick", miss, 0);
            end
        end

        // R8: zero increment stays silent
        run_cfg(2'd1, 1'b0, 1'b1, 3'd0, 16'h0000, 300, b1, b2, s1, s2, sc, bc, dbl, miss);
        chk(sc == 0, "R8 sample ticks", sc, 0);
        chk(bc == 0, "R8 bit ticks", bc, 0);

        // R3: 0xFFFF carries on every step after the first
        run_cfg(2'd3, 1'b0, 1'b1, 3'd0, 16'hFFFF, 40, b1, b2, s1, s2, sc, bc, dbl, miss);
        chk(s1 == 3 && s2 == 4, "R3 back-to-back carries", s2, 4);
        chk(b1 == 18, "R4 bit on 16th carry", b1, 18);
        chk(b2 == 34, "R4 bit on 32nd carry", b2, 34);

        // R6: mode change mid period restarts cleanly
        run_cfg(2'd2, 1'b0, 1'b0, 3'd0, 16'h0, 40, b1, b2, s1, s2, sc, bc, dbl, miss);
        run_cfg(2'd0, 1'b1, 1'b0, 3'd0, 16'h0, 10, b1, b2, s1, s2, sc, bc, dbl, miss);
        chk(b1 == 5, "R6 first tick after mode change", b1, 5);
        chk(sc == 0, "R6 no stray sample tick", sc, 0);

        // R6 R5: prescale change mid period restarts at the new ratio
        run_cfg(2'd0, 1'b0, 1'b0, 3'd0, 16'h0, 7, b1, b2, s1, s2, sc, bc, dbl, miss);
        run_cfg(2'd0, 1'b0, 1'b0, 3'd1, 16'h0, 30, b1, b2, s1, s2, sc, bc, dbl, miss);
        chk(b1 == 25, "R6 first tick after prescale change", b1, 25);

        // R5: select 5 behaves as the power-saving ratio
        run_cfg(2'd0, 1'b1, 1'b0, 3'd5, 16'h0, 1030, b1, b2, s1, s2, sc, bc, dbl, miss);
        chk(b1 == 1025, "R5 select 5 ratio", b1, 1025);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule